// File: doc/BRIEF.md
# Event-to-Interrupt Aggregation Controller

This block gathers single-cycle event pulses from many sources into a set of sticky pending words, and turns them into a few level-sensitive interrupt request lines. Each event arrives as a 7-bit code. The upper two bits pick a pending word and the lower five bits pick a bit inside that word. The event latches that pending bit, and the bit stays set until software clears it.

Each request line has its own bank of enable masks, with one mask word for every pending word. A line is raised while any pending bit that its bank enables is set. Because the banks are separate, one pending event can be routed to any mix of the lines. Software uses a small 32-bit register bus to inspect the pending and mask words, to rewrite the masks, and to clear pending bits by writing ones.

The default build has three pending words of 32 bits, giving 96 event sources, and three request lines. The request lines and the read data are registered outputs.

Top module: `evt_irq_agg`

## Requirements
- R1: After a synchronous reset every pending word, every mask word, `irq_out` and `bus_rdata` are zero.
- R2: An `evt_valid` pulse with code bits [6:5] = w (0, 1 or 2) and bits [4:0] = b sets bit b of pending word w. The bit stays set through any number of idle cycles.
- R3: Event codes whose bits [6:5] equal 3 are ignored and change no pending bit. This includes code 0x7F.
- R4: A bus write to a pending word clears every bit written as 1. Bits written as 0 are left unchanged.
- R5: When an event and a clear write hit the same pending bit in the same cycle, the event wins and the bit stays set.
- R6: The bus address is {group[3:2], word[1:0]}. Group 0 is the pending words, group 1 is mask bank A, group 2 is mask bank B and group 3 is mask bank C. A write to a mask address stores the data, and a read returns it.
- R7: `irq_out[0]`, `irq_out[1]` and `irq_out[2]` (lines A, B, C) are each the OR, over all pending words, of pending AND that line's mask. The line shows the new value in the cycle after the event, write or clear that changed it.
- R8: Addresses with word index 3 are unmapped. Reads of them return 0, and writes to them change no register and no request line.
- R9: `bus_rdata` is loaded in the cycle after a read request, with the register value from before that clock edge. It holds that value until the next read.
- R10: The three request lines are independent. A mask in one bank never raises or lowers another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event pulse strobe |
| evt_code | input | 7 | Event code: pending word in [6:5], bit in [4:0] |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address {group, word} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 3 | Level interrupt requests, line A in bit 0 |

## Verification
Every state change takes effect at the clock edge that samples it. An event, a clear or a mask write is therefore visible on `irq_out` exactly one cycle after it is driven, because the request register is loaded from the next-state values. Read data also arrives one cycle after the request and shows the state from before that edge. The bench drives each stimulus on a falling edge and samples at the following falling edge, so each check lands on the first cycle in which the result is due. It then keeps the design idle to confirm that sticky and held values do not change.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DEF_WORD_W    = 32;
  localparam int DEF_NUM_WORDS = 3;
  localparam int DEF_NUM_LINES = 3;

  // Register groups addressed by the upper address field.
  typedef enum logic [1:0] {
    GRP_PEND   = 2'd0,
    GRP_MASK_A = 2'd1,
    GRP_MASK_B = 2'd2,
    GRP_MASK_C = 2'd3
  } grp_e;
endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 3,
  parameter int SEL_W     = 2,
  parameter int BIT_W     = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        evt_valid,
  input  logic [SEL_W+BIT_W-1:0]      evt_code,
  output logic [NUM_WORDS*WORD_W-1:0] set_vec
);
  logic [SEL_W-1:0] sel;
  logic [BIT_W-1:0] bpos;

  assign sel  = evt_code[SEL_W+BIT_W-1:BIT_W];
  assign bpos = evt_code[BIT_W-1:0];

  // Out-of-range word selects match no slot, so those codes are dropped.
  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      for (int b = 0; b < WORD_W; b++) begin
        set_vec[w*WORD_W+b] = evt_valid && (sel == SEL_W'(w)) && (bpos == BIT_W'(b));
      end
    end
  end

  p_single_set_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set_vec));

  p_valid_sets_one_r2: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && ({1'b0, sel} < (SEL_W+1)'(NUM_WORDS))) |-> ($countones(set_vec) == 1));

  p_bad_code_dropped_r3: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid || ({1'b0, sel} >= (SEL_W+1)'(NUM_WORDS))) |-> (set_vec == '0));
endmodule

// File: rtl/evt_irq_pending.sv
module evt_irq_pending #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_WORDS*WORD_W-1:0] set_vec,
  input  logic [NUM_WORDS*WORD_W-1:0] clr_vec,
  output logic [NUM_WORDS*WORD_W-1:0] pend_q,
  output logic [NUM_WORDS*WORD_W-1:0] pend_nxt
);
  // Set has priority over a same-cycle clear.
  assign pend_nxt = (pend_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ($past(pend_q) & ~$past(clr_vec))) == ($past(pend_q) & ~$past(clr_vec))));

  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
    ((set_vec & clr_vec) != '0) |=> ((pend_q & $past(set_vec & clr_vec)) != '0));
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 3,
  parameter int IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WORD_W-1:0]           wr_data,
  output logic [NUM_WORDS*WORD_W-1:0] mask_q,
  output logic [NUM_WORDS*WORD_W-1:0] mask_nxt
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(w));
    assign mask_nxt[w*WORD_W +: WORD_W] = hit ? wr_data : mask_q[w*WORD_W +: WORD_W];

    always_ff @(posedge clk) begin
      if (rst)      mask_q[w*WORD_W +: WORD_W] <= '0;
      else if (hit) mask_q[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  p_mask_store_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == '0)) |=> (mask_q[WORD_W-1:0] == $past(wr_data)));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int WORD_W    = DEF_WORD_W,
  parameter int NUM_WORDS = DEF_NUM_WORDS,
  parameter int NUM_LINES = DEF_NUM_LINES
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  evt_valid,
  input  logic [1+$clog2(WORD_W):0]             evt_code,
  input  logic                                  bus_valid,
  input  logic                                  bus_write,
  input  logic [$clog2(NUM_LINES+1)+$clog2(NUM_WORDS)-1:0] bus_addr,
  input  logic [WORD_W-1:0]                     bus_wdata,
  output logic [WORD_W-1:0]                     bus_rdata,
  output logic [NUM_LINES-1:0]                  irq_out
);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int SEL_W  = 2;
  localparam int GRP_W  = $clog2(NUM_LINES+1);
  localparam int IDX_W  = $clog2(NUM_WORDS);
  localparam int ADDR_W = GRP_W + IDX_W;
  localparam int VEC_W  = NUM_WORDS*WORD_W;

  logic [GRP_W-1:0] grp;
  logic [IDX_W-1:0] idx;
  logic             wr, rd;

  assign grp = bus_addr[ADDR_W-1:IDX_W];
  assign idx = bus_addr[IDX_W-1:0];
  assign wr  = bus_valid && bus_write;
  assign rd  = bus_valid && !bus_write;

  logic [VEC_W-1:0] set_vec, clr_vec, pend_q, pend_nxt;
  logic [VEC_W-1:0] mask_q   [NUM_LINES];
  logic [VEC_W-1:0] mask_nxt [NUM_LINES];
  logic [NUM_LINES-1:0] irq_nxt;
  logic [WORD_W-1:0] rd_mux;

  evt_irq_decode #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W), .BIT_W(BIT_W)) u_decode (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code), .set_vec(set_vec));

  // Write-one-to-clear strobe toward the addressed pending word only.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_clr
    assign clr_vec[w*WORD_W +: WORD_W] =
      (wr && (grp == GRP_W'(GRP_PEND)) && (idx == IDX_W'(w))) ? bus_wdata : '0;
  end

  evt_irq_pending #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_pending (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .pend_q(pend_q), .pend_nxt(pend_nxt));

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    evt_irq_mask #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_mask (
      .clk(clk), .rst(rst),
      .wr_en(wr && (grp == GRP_W'(l+1))), .wr_idx(idx), .wr_data(bus_wdata),
      .mask_q(mask_q[l]), .mask_nxt(mask_nxt[l]));

    // Next-state evaluation keeps the line one register from its cause.
    assign irq_nxt[l] = |(pend_nxt & mask_nxt[l]);

    p_line_level_r7: assert property (@(posedge clk) disable iff (rst)
      irq_out[l] == |(pend_q & mask_q[l]));
  end

  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= irq_nxt;
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (idx == IDX_W'(w)) begin
        if (grp == GRP_W'(GRP_PEND)) rd_mux = pend_q[w*WORD_W +: WORD_W];
        for (int l = 0; l < NUM_LINES; l++) begin
          if (grp == GRP_W'(l+1)) rd_mux = mask_q[l][w*WORD_W +: WORD_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  p_read_pend0_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && (grp == '0) && (idx == '0)) |=> (bus_rdata == $past(pend_q[WORD_W-1:0])));

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));

  if (NUM_WORDS < (1 << IDX_W)) begin : g_hole
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
      (rd && (idx == IDX_W'((1 << IDX_W) - 1))) |=> (bus_rdata == '0));
  end
endmodule

// File: tb/evt_irq_agg_bench.sv
module evt_irq_agg_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_valid = 1'b0;
  logic [6:0]  evt_code = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] pend_m [3];
  logic [31:0] mask_m [3][3];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_agg u_evt_irq_agg (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_code(evt_code),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] irq_model();
    logic [2:0] r = '0;
    for (int l = 0; l < 3; l++)
      for (int w = 0; w < 3; w++)
        if ((pend_m[w] & mask_m[l][w]) != 0) r[l] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] adr(int g, int w);
    return {2'(g), 2'(w)};
  endfunction

  task automatic step();
    @(negedge clk);
    evt_valid = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic post_event(logic [6:0] code);
    evt_valid = 1'b1; evt_code = code;
    if (code[6:5] != 2'd3) pend_m[code[6:5]][code[4:0]] = 1'b1;
    step();
  endtask

  task automatic bus_wr(int g, int w, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = adr(g, w); bus_wdata = d;
    if (w < 3) begin
      if (g == 0) pend_m[w] = pend_m[w] & ~d;
      else        mask_m[g-1][w] = d;
    end
    step();
  endtask

  task automatic bus_rd_check(string req, int g, int w);
    logic [31:0] exp;
    exp = (w > 2) ? 32'h0 : (g == 0) ? pend_m[w] : mask_m[g-1][w];
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = adr(g, w);
    step();
    check(req, bus_rdata, exp);
  endtask

  task automatic check_irq(string req);
    check(req, {29'h0, irq_out}, {29'h0, irq_model()});
  endtask

  task automatic t_reset();
    check("R1 irq after reset", {29'h0, irq_out}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    for (int g = 0; g < 4; g++)
      for (int w = 0; w < 3; w++)
        bus_rd_check("R1 register zero", g, w);
  endtask

  task automatic t_decode();
    post_event(7'h00);
    post_event(7'h25);
    post_event(7'h5F);
    check_irq("R7 no masks no irq");
    repeat (4) step();
    bus_rd_check("R2 word0 bit0", 0, 0);
    bus_rd_check("R2 word1 bit5", 0, 1);
    bus_rd_check("R2 word2 bit31", 0, 2);
    check("R2 word2 literal", bus_rdata, 32'h8000_0000);
  endtask

  task automatic t_ignored();
    post_event(7'h60);
    post_event(7'h7F);
    post_event(7'h6A);
    for (int w = 0; w < 3; w++) bus_rd_check("R3 invalid code ignored", 0, w);
  endtask

  task automatic t_masks();
    bus_wr(1, 1, 32'h0000_0020);
    check("R7 line A rises next cycle", {29'h0, irq_out}, 32'h1);
    bus_wr(2, 2, 32'h8000_0000);
    check("R10 line B independent", {29'h0, irq_out}, 32'h3);
    bus_wr(3, 0, 32'h0000_0002);
    check("R10 line C stays low", {29'h0, irq_out}, 32'h3);
    bus_rd_check("R6 mask A word1", 1, 1);
    bus_rd_check("R6 mask B word2", 2, 2);
    bus_rd_check("R6 mask C word0", 3, 0);
  endtask

  task automatic t_clear();
    bus_wr(0, 1, 32'h0000_0020);
    check("R4 line A drops after clear", {29'h0, irq_out}, 32'h2);
    bus_rd_check("R4 word1 cleared", 0, 1);
    bus_wr(0, 2, 32'h0000_0000);
    bus_rd_check("R4 zero write keeps bits", 0, 2);
    post_event(7'h01);
    check("R7 line C rises on event", {29'h0, irq_out}, 32'h6);
  endtask

  task automatic t_collide();
    evt_valid = 1'b1; evt_code = 7'h41;
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = adr(0, 2); bus_wdata = 32'h8000_0002;
    pend_m[2] = (pend_m[2] & ~32'h8000_0002) | 32'h0000_0002;
    step();
    check_irq("R5 collision irq");
    bus_rd_check("R5 event beats clear", 0, 2);
    check("R5 literal word2", bus_rdata, 32'h0000_0002);
  endtask

  task automatic t_unmapped();
    bus_wr(0, 3, 32'hFFFF_FFFF);
    bus_wr(1, 3, 32'hFFFF_FFFF);
    check_irq("R8 irq unchanged");
    bus_rd_check("R8 unmapped reads zero", 1, 3);
    bus_rd_check("R8 unmapped pend reads zero", 0, 3);
    for (int w = 0; w < 3; w++) bus_rd_check("R8 pending untouched", 0, w);
    bus_rd_check("R8 mask A word1 untouched", 1, 1);
  endtask

  task automatic t_rdata();
    logic [31:0] held;
    bus_rd_check("R9 read word0", 0, 0);
    held = pend_m[0];
    post_event(7'h1F);
    repeat (2) step();
    check("R9 rdata held", bus_rdata, held);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = adr(0, 0);
    evt_valid = 1'b1; evt_code = 7'h10;
    step();
    check("R9 pre-edge value", bus_rdata, pend_m[0]);
    pend_m[0][16] = 1'b1;
    bus_rd_check("R9 later read sees event", 0, 0);
    check_irq("R7 final level");
  endtask

  initial begin
    for (int w = 0; w < 3; w++) begin
      pend_m[w] = '0;
      for (int l = 0; l < 3; l++) mask_m[l][w] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_ignored();
    t_masks();
    t_clear();
    t_collide();
    t_unmapped();
    t_rdata();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule